// File: doc/BRIEF.md
# Processor Status Word Register

This block holds the condition flags and the two privilege-related control bits of a small processor. It sits beside an ALU. After every operation the ALU presents the result, its carry-out, its overflow indication and a class code. The block updates the flags as a side effect, following fixed rules for each class. Software never sets the flags directly. A program observes them only through the branch-condition output. A two-bit selector on that output picks one of four tests against the stored flags.

The same register carries an interrupt-enable bit and a supervisor bit. A single packed-word write port can reload the whole word, but only while the supervisor bit is set. A write attempted in user mode is dropped. It produces a one-cycle privilege-fault pulse, which the surrounding core can turn into a trap. Reset places the core in supervisor mode with interrupts disabled and every flag clear.

Packed word layout: bit 0 zero (Z), bit 1 sign (S), bit 2 carry (C), bit 3 overflow (V), bit 4 equal (E), bit 5 interrupt enable (IE), bit 6 supervisor (SUP).

Top module: `status_word_reg`

## Requirements
- R1: After reset, Z, S, C, V, E and IE are 0, SUP is 1, and priv_fault is 0.
- R2: An arithmetic operation (op_valid=1, op_class=01) sets Z to 1 exactly when the result is all zeros. It sets S to the result's top bit, C to alu_carry and V to alu_ovf. It leaves E unchanged. The new values are visible after the next rising clock edge.
- R3: A logic operation (op_class=10) sets Z and S as in R2, clears C and V, and leaves E unchanged.
- R4: A compare operation (op_class=11) updates Z, S, C and V as in R2, and sets E to 1 exactly when the result is all zeros.
- R5: A move operation (op_class=00) leaves every flag unchanged. So does any cycle with op_valid=0.
- R6: A write (wr_en=1) while SUP is 1 loads wr_word into the whole packed word at the next edge. The layout is the one given above.
- R7: A write while SUP is 0 changes nothing. priv_fault is 1 in the cycle that follows such a write, and 0 after any cycle without one.
- R8: When an accepted write and a flag-updating operation arrive in the same cycle, the written value wins.
- R9: branch_taken is a combinational function of the stored flags. cond_sel=00 gives Z, 01 gives not Z, 10 gives Z or (S xor V), and 11 gives not Z and not (S xor V).
- R10: status_word always equals the individual flag and control outputs packed in the layout above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_valid | input | 1 | An ALU operation completes this cycle |
| op_class | input | 2 | 00 move, 01 arithmetic, 10 logic, 11 compare |
| alu_result | input | DATA_W | ALU result |
| alu_carry | input | 1 | Carry out of addition, or borrow out of subtraction |
| alu_ovf | input | 1 | Signed overflow of the operation |
| wr_en | input | 1 | Packed-word write request |
| wr_word | input | 7 | Value to load into the packed word |
| cond_sel | input | 2 | Branch condition selector |
| flag_z | output | 1 | Zero flag |
| flag_s | output | 1 | Sign flag |
| flag_c | output | 1 | Carry/borrow flag |
| flag_v | output | 1 | Overflow flag |
| flag_e | output | 1 | Equal flag |
| irq_en | output | 1 | Interrupt enable bit |
| sup_mode | output | 1 | Supervisor bit |
| status_word | output | 7 | Packed status word |
| branch_taken | output | 1 | Selected condition holds |
| priv_fault | output | 1 | One-cycle pulse after a rejected user-mode write |

## Verification
The hardest situation to reach from the ports is a rejected write. It needs user mode, and the only way out of supervisor mode is a privileged write that clears SUP itself. Only reset brings the block back. The stimulus therefore runs all operation and branch sweeps in supervisor mode first. It then drops to user mode with one write, tests the rejected writes, checks that operations still update flags in user mode, and finally reapplies reset to check the starting state again.

// File: rtl/psw_pkg.sv
package psw_pkg;

  typedef enum logic [1:0] {
    CLS_MOVE  = 2'b00,
    CLS_ARITH = 2'b01,
    CLS_LOGIC = 2'b10,
    CLS_CMP   = 2'b11
  } op_cls_e;

  typedef enum logic [1:0] {
    BR_ZERO    = 2'b00,
    BR_NONZERO = 2'b01,
    BR_LE      = 2'b10,
    BR_GT      = 2'b11
  } br_sel_e;

  // bit 0 is z, bit 4 is e
  typedef struct packed {
    logic e;
    logic v;
    logic c;
    logic s;
    logic z;
  } cc_flags_t;

  localparam int unsigned CC_W   = $bits(cc_flags_t);
  localparam int unsigned WORD_W = CC_W + 2;
  localparam int unsigned IE_BIT  = CC_W;
  localparam int unsigned SUP_BIT = CC_W + 1;

  function automatic logic sign_less(input cc_flags_t f);
    return f.s ^ f.v;
  endfunction

  function automatic logic cond_eval(input br_sel_e sel, input cc_flags_t f);
    logic r;
    case (sel)
      BR_ZERO:    r = f.z;
      BR_NONZERO: r = ~f.z;
      BR_LE:      r = f.z | sign_less(f);
      default:    r = ~f.z & ~sign_less(f);
    endcase
    return r;
  endfunction

endpackage

// File: rtl/psw_flag_calc.sv
module psw_flag_calc
  import psw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              op_valid,
  input  op_cls_e           op_class,
  input  logic [DATA_W-1:0] result,
  input  logic              carry,
  input  logic              ovf,
  input  cc_flags_t         cur,
  output cc_flags_t         nxt,
  output logic              upd
);
  logic res_zero;
  logic res_msb;

  assign res_zero = (result == '0);
  assign res_msb  = result[DATA_W-1];

  always_comb begin
    nxt = cur;
    upd = 1'b0;
    if (op_valid) begin
      case (op_class)
        CLS_ARITH: begin
          upd = 1'b1;
          nxt.z = res_zero;
          nxt.s = res_msb;
          nxt.c = carry;
          nxt.v = ovf;
        end
        CLS_LOGIC: begin
          upd = 1'b1;
          nxt.z = res_zero;
          nxt.s = res_msb;
          nxt.c = 1'b0;
          nxt.v = 1'b0;
        end
        CLS_CMP: begin
          upd = 1'b1;
          nxt.z = res_zero;
          nxt.s = res_msb;
          nxt.c = carry;
          nxt.v = ovf;
          nxt.e = res_zero;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/psw_priv_gate.sv
module psw_priv_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic sup_now,
  output logic wr_accept,
  output logic wr_reject,
  output logic priv_fault
);
  assign wr_accept = wr_en & sup_now;
  assign wr_reject = wr_en & ~sup_now;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) priv_fault <= 1'b0;
    else        priv_fault <= wr_reject;
  end

  // R7
  fault_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sup_now) |=> priv_fault);

  // R7
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !sup_now) |=> !priv_fault);
endmodule

// File: rtl/psw_branch_eval.sv
module psw_branch_eval
  import psw_pkg::*;
(
  input  br_sel_e   sel,
  input  cc_flags_t flags,
  output logic      taken
);
  assign taken = cond_eval(sel, flags);
endmodule

// File: rtl/status_word_reg.sv
module status_word_reg
  import psw_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [1:0]        op_class,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_ovf,
  input  logic              wr_en,
  input  logic [6:0]        wr_word,
  input  logic [1:0]        cond_sel,
  output logic              flag_z,
  output logic              flag_s,
  output logic              flag_c,
  output logic              flag_v,
  output logic              flag_e,
  output logic              irq_en,
  output logic              sup_mode,
  output logic [6:0]        status_word,
  output logic              branch_taken,
  output logic              priv_fault
);
  cc_flags_t flags_q, flags_nxt;
  logic      ie_q, sup_q;
  logic      flag_upd, wr_accept, wr_reject;

  psw_flag_calc #(.DATA_W(DATA_W)) u_calc (
    .op_valid (op_valid),
    .op_class (op_cls_e'(op_class)),
    .result   (alu_result),
    .carry    (alu_carry),
    .ovf      (alu_ovf),
    .cur      (flags_q),
    .nxt      (flags_nxt),
    .upd      (flag_upd)
  );

  psw_priv_gate u_gate (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .sup_now    (sup_q),
    .wr_accept  (wr_accept),
    .wr_reject  (wr_reject),
    .priv_fault (priv_fault)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      ie_q    <= 1'b0;
      sup_q   <= 1'b1;
    end else if (wr_accept) begin
      flags_q <= cc_flags_t'(wr_word[CC_W-1:0]);
      ie_q    <= wr_word[IE_BIT];
      sup_q   <= wr_word[SUP_BIT];
    end else if (flag_upd) begin
      flags_q <= flags_nxt;
    end
  end

  psw_branch_eval u_br (
    .sel   (br_sel_e'(cond_sel)),
    .flags (flags_q),
    .taken (branch_taken)
  );

  assign flag_z      = flags_q.z;
  assign flag_s      = flags_q.s;
  assign flag_c      = flags_q.c;
  assign flag_v      = flags_q.v;
  assign flag_e      = flags_q.e;
  assign irq_en      = ie_q;
  assign sup_mode    = sup_q;
  assign status_word = {sup_q, ie_q, flags_q};

  // R7
  user_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_reject |=> ($stable(ie_q) && $stable(sup_q)));

  // R5
  move_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_accept && !(op_valid && op_class != 2'b00)) |=> $stable(flags_q));

  // R3
  logic_clears_cv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'b10 && !wr_accept) |=> (!flags_q.c && !flags_q.v));

  // R2
  zero_tracks_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 2'b01 && !wr_accept) |=> (flags_q.z == ($past(alu_result) == '0)));

  // R8
  write_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> (status_word == $past(wr_word)));
endmodule

// File: tb/sim_status_word_reg.sv
module sim_status_word_reg;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       op_valid;
  logic [1:0] op_class;
  logic [7:0] alu_result;
  logic       alu_carry, alu_ovf, wr_en;
  logic [6:0] wr_word;
  logic [1:0] cond_sel;
  logic       flag_z, flag_s, flag_c, flag_v, flag_e, irq_en, sup_mode;
  logic [6:0] status_word;
  logic       branch_taken, priv_fault;

  int vectors = 0;
  int errors  = 0;
  logic [6:0] model;

  always #5 clk = ~clk;

  status_word_reg #(.DATA_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
    .alu_result(alu_result), .alu_carry(alu_carry), .alu_ovf(alu_ovf),
    .wr_en(wr_en), .wr_word(wr_word), .cond_sel(cond_sel),
    .flag_z(flag_z), .flag_s(flag_s), .flag_c(flag_c), .flag_v(flag_v),
    .flag_e(flag_e), .irq_en(irq_en), .sup_mode(sup_mode),
    .status_word(status_word), .branch_taken(branch_taken),
    .priv_fault(priv_fault)
  );

  task automatic check(input string tag, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  // expected word after one op, by arithmetic on bit positions
  function automatic logic [6:0] predict(input logic [6:0] w, input int cls,
                                         input int r, input int c, input int v);
    logic [6:0] n = w;
    int zf = (r == 0) ? 1 : 0;
    int sf = (r >= 128) ? 1 : 0;
    if (cls == 0) return w;
    n[0] = zf[0];
    n[1] = sf[0];
    n[2] = (cls == 2) ? 1'b0 : c[0];
    n[3] = (cls == 2) ? 1'b0 : v[0];
    if (cls == 3) n[4] = zf[0];
    return n;
  endfunction

  function automatic logic br_model(input logic [6:0] w, input int sel);
    int z = w[0], lt = (w[1] != w[3]) ? 1 : 0;
    case (sel)
      0: return z == 1;
      1: return z == 0;
      2: return (z == 1) || (lt == 1);
      default: return (z == 0) && (lt == 0);
    endcase
  endfunction

  task automatic idle_inputs();
    op_valid = 0; op_class = 0; alu_result = 0; alu_carry = 0; alu_ovf = 0;
    wr_en = 0; wr_word = 0; cond_sel = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    idle_inputs();
    rst_n = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    model = 7'b1000000;
    check("R1 word", status_word, 7'h40);
    check("R1 fault", priv_fault, 0);
  endtask

  task automatic apply_op(input int cls, input int r, input int c, input int v);
    op_valid = 1; op_class = cls[1:0]; alu_result = r[7:0];
    alu_carry = c[0]; alu_ovf = v[0];
    @(negedge clk);
    op_valid = 0;
    model = predict(model, cls, r, c, v);
  endtask

  task automatic sup_write(input logic [6:0] w);
    wr_en = 1; wr_word = w;
    @(negedge clk);
    wr_en = 0;
    model = w;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    do_reset();

    // R2 R3 R4 R5 sweep in supervisor mode
    for (int cls = 0; cls < 4; cls++)
      for (int r = 0; r < 256; r++)
        for (int cv = 0; cv < 4; cv++) begin
          apply_op(cls, r, cv & 1, cv >> 1);
          case (cls)
            0: check("R5 move", status_word, model);
            1: check("R2 arith", status_word, model);
            2: check("R3 logic", status_word, model);
            default: check("R4 compare", status_word, model);
          endcase
          check("R10 pack", {sup_mode, irq_en, flag_e, flag_v, flag_c, flag_s, flag_z}, status_word);
        end

    // R5: op_valid low with arith class
    op_class = 2'b01; alu_result = 8'h00; alu_carry = 1; alu_ovf = 1;
    @(negedge clk);
    check("R5 invalid", status_word, model);

    // R6 R9: load every flag pattern, evaluate every condition
    for (int w = 0; w < 32; w++) begin
      sup_write(7'(w) | 7'h40 | ((w & 1) ? 7'h20 : 7'h00));
      check("R6 load", status_word, model);
      for (int cs = 0; cs < 4; cs++) begin
        cond_sel = cs[1:0];
        #1;
        check("R9 branch", branch_taken, br_model(model, cs));
      end
    end

    // R8: write and arith op in the same cycle
    op_valid = 1; op_class = 2'b01; alu_result = 8'h00; alu_carry = 1; alu_ovf = 1;
    sup_write(7'h5E);
    op_valid = 0;
    check("R8 priority", status_word, 7'h5E);

    // R7: drop to user mode, then attempt writes
    sup_write(7'h2A);
    check("R6 user entry", status_word, 7'h2A);
    check("R7 no fault on accepted", priv_fault, 0);
    wr_en = 1; wr_word = 7'h7F;
    @(negedge clk);
    wr_en = 0;
    check("R7 ignored", status_word, 7'h2A);
    check("R7 fault pulse", priv_fault, 1);
    @(negedge clk);
    check("R7 fault ends", priv_fault, 0);
    // back-to-back rejected writes
    wr_en = 1; wr_word = 7'h40;
    @(negedge clk);
    check("R7 fault 1", priv_fault, 1);
    @(negedge clk);
    wr_en = 0;
    check("R7 fault 2", priv_fault, 1);
    check("R7 still user", sup_mode, 0);
    @(negedge clk);
    check("R7 quiet", priv_fault, 0);

    // flags still follow ops in user mode
    apply_op(3, 0, 1, 0);
    check("R4 user compare", status_word, model);
    apply_op(2, 200, 1, 1);
    check("R3 user logic", status_word, model);

    // R1 again after reset
    do_reset();
    check("R1 sup", sup_mode, 1);
    check("R1 ie", irq_en, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule